// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This is a single-port synchronous RAM whose command and data phases are pipelined. Reads and writes can be issued back to back in any mix, with no idle cycles between them. A read returns its word two enabled clock edges after the address was taken. A write takes its data from `din` at that same pipeline position. Because both kinds of access use the same data slot, the shared data bus is never left empty or turned around. The bidirectional data bus is split into `din`, `dout` and `dout_en`, where `dout_en` is the tri-state enable.

Write data is held in a one-entry late-write buffer and only goes into the array when the next write's data arrives. Reads check this buffer and merge the pending bytes under their byte enables, so a read always returns the latest written value. Three chip selects must all be active for an access to happen. A burst strobe repeats the previous cycle's command type at the next address in a four-word linear wrap. A hold input freezes the whole block.

Top module: `pipe_sram`

## Requirements
- R1: A read command captured at an enabled edge drives the addressed word on `dout`, with `dout_en` high, right after the second enabled edge that follows.
- R2: A write captured at an enabled edge takes its data from `din` at the second enabled edge after it, and later reads of that address return that data.
- R3: Read and write commands may alternate on consecutive cycles in any order, with no idle cycle, and every access stays correct.
- R4: Only byte lanes whose `byte_we` bit is 1 are written. Lane l is bits [9l+8:9l], so bit 0 selects bits 8:0 and bit 1 selects bits 17:9.
- R5: A read of an address whose most recent write is still held in the write buffer returns that write's lanes merged over the older stored lanes.
- R6: With `burst` low and any of `cs0`, `cs1`, `cs2` low, the cycle is a deselect and the stored contents are not changed.
- R7: `dout_en` is low in the data slot of a write or a deselect.
- R8: While `hold` is 1, all inputs are ignored and all state, including `dout` and `dout_en`, keeps its value. Pipeline delays count only edges where `hold` is 0.
- R9: With `burst` high, the new command has the previous command's type and byte enables. Its address has the low two bits incremented modulo 4 and the upper bits unchanged. A burst after a deselect stays a deselect.
- R10: After reset, `dout_en` is low and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 = freeze the block and ignore inputs |
| cs0 | input | 1 | Chip select 0, active high |
| cs1 | input | 1 | Chip select 1, active high |
| cs2 | input | 1 | Chip select 2, active high |
| burst | input | 1 | 1 = continue the previous command at the next address; 0 = new command |
| wr | input | 1 | 1 = write, 0 = read |
| byte_we | input | LANES | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, sampled in the write's data slot |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Drive enable for the read data slot |

## Verification
The hardest case to reach is a read that must be served partly from the late-write buffer and partly from the array. This needs two partial writes to one address in a row, followed at once by a read of that address. The stimulus issues exactly that sequence, and also issues a read directly behind a single write. Hold cycles are placed inside mixed read/write streams so that the pipeline stalls while both a read and a write are in flight. A bench model tracks how many enabled edges have passed and what each data slot should contain.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
    // command carried down the pipeline
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // width of the wrapping burst counter (low address bits)
    localparam int BURST_W = 2;
endpackage

// File: rtl/pipe_sram_cmd.sv
module pipe_sram_cmd
    import pipe_sram_pkg::*;
#(
    parameter int AW = 5,
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          cs0,
    input  logic          cs1,
    input  logic          cs2,
    input  logic          burst,
    input  logic          wr,
    input  logic [NL-1:0] byte_we,
    input  logic [AW-1:0] addr,
    output op_e           s1_op,
    output logic [AW-1:0] s1_addr,
    output logic [NL-1:0] s1_be
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [NL-1:0] be;
    } cmd_t;

    typedef struct packed {
        cmd_t s0;   // captured at the last enabled edge
        cmd_t s1;   // one enabled edge older: owns the next data slot
    } st_t;

    st_t  st_d, st_q;
    logic sel_all;

    always_comb begin
        st_d    = st_q;
        sel_all = cs0 & cs1 & cs2;
        if (!hold) begin
            st_d.s1 = st_q.s0;
            if (burst) begin
                st_d.s0.addr[BURST_W-1:0] = st_q.s0.addr[BURST_W-1:0] + BURST_W'(1);
            end else begin
                st_d.s0.addr = addr;
                st_d.s0.be   = byte_we;
                st_d.s0.op   = !sel_all ? OP_IDLE : (wr ? OP_WR : OP_RD);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_op   = st_q.s1.op;
    assign s1_addr = st_q.s1.addr;
    assign s1_be   = st_q.s1.be;

    // R6: an incomplete select on a new command yields an idle slot
    p_desel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !burst && !(cs0 && cs1 && cs2)) |=> (st_q.s0.op == OP_IDLE));

    // R9: burst keeps the command type and steps the wrapping counter
    p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && burst) |=> ((st_q.s0.addr[BURST_W-1:0] ==
                               $past(st_q.s0.addr[BURST_W-1:0]) + BURST_W'(1))
                              && (st_q.s0.op == $past(st_q.s0.op))
                              && (st_q.s0.addr[AW-1:BURST_W] == $past(st_q.s0.addr[AW-1:BURST_W]))));

    // R8: a held cycle leaves the command pipeline untouched
    p_cmd_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q));
endmodule

// File: rtl/pipe_sram_core.sv
module pipe_sram_core
    import pipe_sram_pkg::*;
#(
    parameter int AW = 5,
    parameter int NL = 2,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  op_e              s1_op,
    input  logic [AW-1:0]    s1_addr,
    input  logic [NL-1:0]    s1_be,
    input  logic [NL*LW-1:0] din,
    output logic [NL*LW-1:0] dout,
    output logic             dout_en
);
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          pv;   // late-write buffer valid
        logic [AW-1:0] pa;
        logic [NL-1:0] pb;
        logic [DW-1:0] pd;
        logic          oe;
        logic [DW-1:0] od;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic          commit;
    logic          hit;
    logic [DW-1:0] rd_word;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        hit    = st_q.pv && (st_q.pa == s1_addr);
        for (int l = 0; l < NL; l++) begin
            rd_word[l*LW +: LW] = (hit && st_q.pb[l]) ? st_q.pd[l*LW +: LW]
                                                      : mem[s1_addr][l*LW +: LW];
        end
        if (!hold) begin
            st_d.oe = (s1_op == OP_RD);
            st_d.od = (s1_op == OP_RD) ? rd_word : '0;
            if (s1_op == OP_WR) begin
                commit  = st_q.pv;
                st_d.pv = 1'b1;
                st_d.pa = s1_addr;
                st_d.pb = s1_be;
                st_d.pd = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // array: the buffered write retires when the next write's data lands
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < NL; l++) begin
                if (st_q.pb[l]) mem[st_q.pa][l*LW +: LW] <= st_q.pd[l*LW +: LW];
            end
        end
    end

    assign dout    = st_q.od;
    assign dout_en = st_q.oe;

    // R7: the drive enable follows the kind of access owning the slot
    p_oe_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hold) |-> (dout_en == ($past(s1_op) == OP_RD)));

    // R8: outputs are frozen across a held edge
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(dout) && $stable(dout_en)));

    // R5: a full-word hit in the write buffer is returned verbatim
    p_fwd_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && s1_op == OP_RD && st_q.pv && st_q.pa == s1_addr && (&st_q.pb))
        |=> (dout == $past(st_q.pd)));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    cs0,
    input  logic                    cs1,
    input  logic                    cs2,
    input  logic                    burst,
    input  logic                    wr,
    input  logic [LANES-1:0]        byte_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;
    logic [DATA_W-1:0] rd_q;

    pipe_sram_cmd #(.AW(ADDR_W), .NL(LANES)) i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .cs0     (cs0),
        .cs1     (cs1),
        .cs2     (cs2),
        .burst   (burst),
        .wr      (wr),
        .byte_we (byte_we),
        .addr    (addr),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s1_be   (s1_be)
    );

    pipe_sram_core #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s1_be   (s1_be),
        .din     (din),
        .dout    (rd_q),
        .dout_en (dout_en)
    );

    assign dout = rd_q;

    // R10: nothing is driven in the first cycle out of reset
    p_rst_quiet_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> !dout_en);
endmodule

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        cs0 = 1'b0, cs1 = 1'b0, cs2 = 1'b0;
    logic        burst = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  byte_we = 2'b00;
    logic [4:0]  addr = '0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    int stepn  = 0;
    bit done   = 0;

    // bench model: 0 idle, 1 read, 2 write
    int          m0_op = 0, m1_op = 0;
    logic [4:0]  m0_addr = '0, m1_addr = '0;
    logic [1:0]  m0_be = '0, m1_be = '0;
    logic [17:0] ref_mem [32];

    always #10 clk = ~clk;

    pipe_sram i_pipe_sram (
        .clk(clk), .rst_n(rst_n), .hold(hold), .cs0(cs0), .cs1(cs1), .cs2(cs2),
        .burst(burst), .wr(wr), .byte_we(byte_we), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic h, input logic [2:0] cs, input logic b, input logic w,
                        input logic [1:0] be, input logic [4:0] a, input string tag);
        logic [17:0] wd;
        logic [17:0] pd;
        logic        pe;
        int          n_op;
        logic [4:0]  n_addr;
        logic [1:0]  n_be;
        @(negedge clk);
        wd = 18'((stepn * 7919 + 21) % 262144);
        stepn++;
        hold = h; cs0 = cs[0]; cs1 = cs[1]; cs2 = cs[2];
        burst = b; wr = w; byte_we = be; addr = a; din = wd;
        pd = dout; pe = dout_en;
        @(posedge clk);
        #1;
        if (h) begin
            check(dout === pd && dout_en === pe, tag, {dout_en, dout[16:0]}, {pe, pd[16:0]});
        end else begin
            if (m1_op == 1) begin
                check(dout_en === 1'b1 && dout === ref_mem[m1_addr], tag, dout, ref_mem[m1_addr]);
            end else begin
                check(dout_en === 1'b0, tag, 18'(dout_en), 18'd0);
            end
            if (m1_op == 2) begin
                for (int l = 0; l < 2; l++)
                    if (m1_be[l]) ref_mem[m1_addr][l*9 +: 9] = wd[l*9 +: 9];
            end
            if (b) begin
                n_op = m0_op; n_be = m0_be;
                n_addr = {m0_addr[4:2], m0_addr[1:0] + 2'd1};
            end else begin
                n_op = (&cs) ? (w ? 2 : 1) : 0; n_addr = a; n_be = be;
            end
            m1_op = m0_op; m1_addr = m0_addr; m1_be = m0_be;
            m0_op = n_op;  m0_addr = n_addr;  m0_be = n_be;
        end
    endtask

    task automatic flush(input string tag);
        step(0, 3'b000, 0, 0, 2'b00, 5'd0, tag);
        step(0, 3'b000, 0, 0, 2'b00, 5'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check(dout_en === 1'b0, "R10", 18'(dout_en), 18'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(dout_en === 1'b0, "R10", 18'(dout_en), 18'd0);

        // R2: fill the whole array, then R1: read it back
        for (int a = 0; a < 32; a++) step(0, 3'b111, 0, 1, 2'b11, 5'(a), "R2");
        for (int a = 0; a < 32; a++) step(0, 3'b111, 0, 0, 2'b11, 5'(a), "R1");
        flush("R1");

        // R3: read and write alternating every cycle
        for (int i = 0; i < 64; i++) step(0, 3'b111, 0, i[0], 2'b11, 5'((i * 11) % 32), "R3");
        for (int i = 0; i < 48; i++) step(0, 3'b111, 0, i[1] ^ i[0], 2'b11, 5'((i * 7) % 32), "R3");
        flush("R3");

        // R4: every lane-enable pattern
        for (int be = 0; be < 4; be++) begin
            step(0, 3'b111, 0, 1, 2'(be), 5'(be + 8), "R4");
            step(0, 3'b111, 0, 1, 2'b11, 5'(be + 20), "R4");
            flush("R4");
            step(0, 3'b111, 0, 0, 2'b11, 5'(be + 8), "R4");
            flush("R4");
        end

        // R5: reads that hit the write buffer
        step(0, 3'b111, 0, 1, 2'b11, 5'd5, "R5");
        step(0, 3'b111, 0, 0, 2'b11, 5'd5, "R5");
        step(0, 3'b111, 0, 1, 2'b01, 5'd5, "R5");
        step(0, 3'b111, 0, 1, 2'b10, 5'd5, "R5");
        step(0, 3'b111, 0, 0, 2'b00, 5'd5, "R5");
        step(0, 3'b111, 0, 1, 2'b10, 5'd6, "R5");
        step(0, 3'b111, 0, 0, 2'b00, 5'd6, "R5");
        flush("R5");

        // R6,R7: every incomplete select pattern with a write request
        for (int c = 0; c < 7; c++) step(0, 3'(c), 0, 1, 2'b11, 5'd12, "R6,R7");
        flush("R6,R7");
        step(0, 3'b111, 0, 0, 2'b11, 5'd12, "R6");
        flush("R6");

        // R8: holds inside a mixed stream
        for (int i = 0; i < 60; i++)
            step((i % 3) == 1, 3'b111, 0, i[2], 2'b11, 5'((i * 5) % 32), "R8");
        step(1, 3'b111, 0, 1, 2'b11, 5'd3, "R8");
        step(1, 3'b000, 1, 0, 2'b01, 5'd9, "R8");
        flush("R8");

        // R9: burst write and burst read with wrap, burst after deselect
        step(0, 3'b111, 0, 1, 2'b11, 5'd14, "R9");
        for (int i = 0; i < 4; i++) step(0, 3'b000, 1, 0, 2'b00, 5'd0, "R9");
        flush("R9");
        step(0, 3'b111, 0, 0, 2'b00, 5'd13, "R9");
        for (int i = 0; i < 5; i++) step(0, 3'b000, 1, 1, 2'b11, 5'd31, "R9");
        step(0, 3'b011, 0, 0, 2'b11, 5'd2, "R9");
        for (int i = 0; i < 3; i++) step(0, 3'b111, 1, 1, 2'b11, 5'd2, "R9");
        flush("R9");
        step(0, 3'b111, 0, 0, 2'b11, 5'd2, "R9");
        flush("R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule